// File: doc/BRIEF.md
# Segment Descriptor Privilege Checker

This block decides whether a far control transfer or a data read through a segment selector is allowed. The caller supplies four things: the current privilege level, the 16-bit selector, the 64-bit descriptor that the selector names, and the kind of request. Privilege levels run from 0 to 3. Level 0 is the most privileged and level 3 the least. The block evaluates the request in combinational logic. It returns a registered verdict one cycle after the request strobe: an allow flag, and a two-bit fault code that tells the caller why a request was refused.

Fetching the descriptor from a table happens before this block is used, so it stays with the caller. Gates, task switching and stack switching also stay outside the block. The checker covers three kinds of target: code segments that demand an exact privilege match, conforming code segments that accept less privileged callers, and readable data targets. For a code segment, descriptor bit 42 means "conforming". For a data segment, the same bit gives the expand direction, and it does not affect the verdict.

Top module: `seg_gate_check`

## Requirements
- R1: While rst_n is low, and on the first sample after reset is released, out_valid, out_allow and out_fault are all 0.
- R2: A request presented with req_valid high at a rising edge produces out_valid high for exactly the next cycle, and the verdict appears in that same cycle. While req_valid stays low, out_valid is 0 and out_allow and out_fault hold their last values.
- R3: When the present bit (descriptor bit 47) is 0, the fault is 1 (absent), whatever the other fields hold.
- R4: For a present descriptor whose segment-type bit (bit 44) is 0, meaning a system segment, the fault is 2 (wrong type) for both request kinds.
- R5: A far transfer (req_read = 0) to a memory segment whose executable bit (bit 43) is 0 gives fault 2.
- R6: A far transfer to code with bit 42 = 0 is allowed only when max(cur_lvl, selector[1:0]) equals the DPL in bits 46:45. Otherwise the fault is 3 (privilege).
- R7: A far transfer to code with bit 42 = 1 is allowed when cur_lvl is numerically greater than or equal to the DPL. The requested level selector[1:0] has no effect. Otherwise the fault is 3.
- R8: A read (req_read = 1) of a data segment is allowed when the DPL is numerically at least max(cur_lvl, selector[1:0]). Otherwise the fault is 3. Bit 42 (expand direction) has no effect on the verdict.
- R9: A read of a code segment with the readable bit (bit 41) at 0 gives fault 2. With bit 41 at 1, the read follows the privilege rule of R8.
- R10: Selector bits 15:2, the accessed bit 40, and the base and limit fields have no effect on the verdict.
- R11: The fault codes are 0 none, 1 absent, 2 wrong type and 3 privilege. In any valid result, out_allow is 1 exactly when out_fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_read | input | 1 | 0 = far transfer, 1 = data read |
| cur_lvl | input | 2 | Current privilege level of the caller |
| selector | input | 16 | Segment selector, requested level in bits 1:0 |
| descriptor | input | 64 | Descriptor named by the selector |
| out_valid | output | 1 | Verdict valid, one cycle after the request |
| out_allow | output | 1 | Request allowed |
| out_fault | output | 2 | Fault code |

## Verification
Every decision path ends in a register that is updated only on a request. A wrong decode of a descriptor field, or a wrong level comparison, therefore shows up as a wrong fault code or allow flag in the cycle right after that request strobe, and only for the field combinations that reach the faulty path. For that reason the levels are swept exhaustively for each target kind. A fault in the capture or hold logic shows as a verdict that changes during idle cycles, or as an out_valid that is not a one-cycle echo of the strobe. The idle cycles after each request catch both of these.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_TYPE   = 2'd2,
      FLT_PRIV   = 2'd3
   } fault_e;

   // attribute fields pulled out of one descriptor
   typedef struct packed {
      logic       present;
      logic [1:0] dpl;
      logic       is_mem;
      logic       is_code;
      logic       flavor;    // conforming for code, expand direction for data
      logic       readable;
   } seg_attr_t;

   function automatic logic [1:0] lvl_max(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/seg_attr_decode.sv
module seg_attr_decode
   import seg_chk_pkg::*;
#(
   parameter int DESC_W   = 64,
   parameter int PRES_POS = 47,
   parameter int DPL_LSB  = 45,
   parameter int MEM_POS  = 44,
   parameter int EXEC_POS = 43,
   parameter int FLAV_POS = 42,
   parameter int READ_POS = 41
) (
   input  logic [DESC_W-1:0] desc,
   output seg_attr_t         attr
);
   localparam int TOP_POS = PRES_POS;

   if (TOP_POS >= DESC_W) begin : g_bad_width
      $error("descriptor too narrow for attribute fields");
   end
   if (DPL_LSB + 1 >= PRES_POS) begin : g_bad_dpl
      $error("level field overlaps present bit");
   end

   logic unused_desc;
   assign unused_desc = ^desc;

   always_comb begin
      attr.present  = desc[PRES_POS];
      attr.dpl      = desc[DPL_LSB +: 2];
      attr.is_mem   = desc[MEM_POS];
      attr.is_code  = desc[EXEC_POS];
      attr.flavor   = desc[FLAV_POS];
      attr.readable = desc[READ_POS];
   end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
   import seg_chk_pkg::*;
#(
   parameter int SEL_W   = 16,
   parameter int LVL_W   = 2
) (
   input  seg_attr_t  attr,
   input  logic       is_read,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic [SEL_W-1:0] sel,
   output fault_e     fault
);
   if (LVL_W != 2) begin : g_bad_lvl
      $error("privilege levels must be two bits wide");
   end
   if (SEL_W < LVL_W + 1) begin : g_bad_sel
      $error("selector too narrow");
   end

   logic [LVL_W-1:0] rpl;
   logic [LVL_W-1:0] eff_lvl;
   logic             unused_sel;
   fault_e           jump_fault;
   fault_e           read_fault;

   assign rpl        = sel[LVL_W-1:0];
   assign unused_sel = ^sel;
   assign eff_lvl    = lvl_max(cur_lvl, rpl);

   // far transfer rules
   always_comb begin
      if (!attr.is_code) begin
         jump_fault = FLT_TYPE;
      end else if (attr.flavor) begin
         jump_fault = (cur_lvl >= attr.dpl) ? FLT_NONE : FLT_PRIV;
      end else begin
         jump_fault = (eff_lvl == attr.dpl) ? FLT_NONE : FLT_PRIV;
      end
   end

   // data read rules
   always_comb begin
      if (attr.is_code && !attr.readable) begin
         read_fault = FLT_TYPE;
      end else begin
         read_fault = (attr.dpl >= eff_lvl) ? FLT_NONE : FLT_PRIV;
      end
   end

   // absent before type before privilege
   always_comb begin
      if (!attr.present) begin
         fault = FLT_ABSENT;
      end else if (!attr.is_mem) begin
         fault = FLT_TYPE;
      end else if (is_read) begin
         fault = read_fault;
      end else begin
         fault = jump_fault;
      end
   end
endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
   import seg_chk_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  fault_e in_fault,
   output logic   q_valid,
   output logic   q_allow,
   output fault_e q_fault
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_allow <= 1'b0;
         q_fault <= FLT_NONE;
      end else begin
         q_valid <= in_valid;
         if (in_valid) begin
            q_allow <= (in_fault == FLT_NONE);
            q_fault <= in_fault;
         end
      end
   end
endmodule

// File: rtl/seg_gate_check.sv
module seg_gate_check
   import seg_chk_pkg::*;
#(
   parameter int SEL_W  = 16,
   parameter int DESC_W = 64,
   parameter int LVL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [LVL_W-1:0]  cur_lvl,
   input  logic [SEL_W-1:0]  selector,
   input  logic [DESC_W-1:0] descriptor,
   output logic              out_valid,
   output logic              out_allow,
   output logic [1:0]        out_fault
);
   seg_attr_t attr;
   fault_e    comb_fault;
   fault_e    reg_fault;

   seg_attr_decode #(.DESC_W(DESC_W)) u_decode (
      .desc (descriptor),
      .attr (attr)
   );

   seg_rule_eval #(.SEL_W(SEL_W), .LVL_W(LVL_W)) u_rules (
      .attr    (attr),
      .is_read (req_read),
      .cur_lvl (cur_lvl),
      .sel     (selector),
      .fault   (comb_fault)
   );

   seg_result_reg u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_fault (comb_fault),
      .q_valid  (out_valid),
      .q_allow  (out_allow),
      .q_fault  (reg_fault)
   );

   assign out_fault = reg_fault;
endmodule

// File: rtl/seg_gate_check_sva.sv
module seg_gate_check_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_read,
   input logic [63:0] descriptor,
   input logic        out_valid,
   input logic        out_allow,
   input logic [1:0]  out_fault
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   valid_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(req_valid)));

   // R11
   allow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_allow == (out_fault == 2'd0)));

   // R3
   absent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_valid && !$past(descriptor[47])) |-> (out_fault == 2'd1));

   // R5
   jump_data_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_valid && !$past(req_read) && !$past(descriptor[43])) |-> !out_allow);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(req_valid)) |-> ($stable(out_allow) && $stable(out_fault)));
endmodule

bind seg_gate_check seg_gate_check_sva u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_read   (req_read),
   .descriptor (descriptor),
   .out_valid  (out_valid),
   .out_allow  (out_allow),
   .out_fault  (out_fault)
);

// File: tb/test_seg_gate_check.sv
`timescale 1ns/1ps
module test_seg_gate_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_read = 1'b0;
   logic [1:0]  cur_lvl = 2'd0;
   logic [15:0] selector = 16'd0;
   logic [63:0] descriptor = 64'd0;
   logic        out_valid;
   logic        out_allow;
   logic [1:0]  out_fault;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   seg_gate_check i_seg_gate_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_read   (req_read),
      .cur_lvl    (cur_lvl),
      .selector   (selector),
      .descriptor (descriptor),
      .out_valid  (out_valid),
      .out_allow  (out_allow),
      .out_fault  (out_fault)
   );

   // present(47) dpl(46:45) mem(44) exec(43) flavor(42) readable(41) accessed(40)
   function automatic logic [63:0] mk_desc(input logic p, input logic [1:0] dpl,
         input logic s, input logic x, input logic c, input logic r,
         input logic a, input logic [31:0] fill);
      logic [63:0] d;
      d = {fill[31:24], 8'h00, fill[23:0], fill[15:0], 8'h00};
      d[47] = p; d[46:45] = dpl; d[44] = s; d[43] = x;
      d[42] = c; d[41] = r; d[40] = a;
      return d;
   endfunction

   function automatic logic [1:0] model(input logic rd, input logic [1:0] cl,
         input logic [15:0] sel, input logic [63:0] d);
      logic [1:0] dpl, eff;
      dpl = d[46:45];
      eff = (cl > sel[1:0]) ? cl : sel[1:0];
      if (!d[47]) return 2'd1;
      if (!d[44]) return 2'd2;
      if (!rd) begin
         if (!d[43]) return 2'd2;
         if (d[42]) return (cl >= dpl) ? 2'd0 : 2'd3;
         return (eff == dpl) ? 2'd0 : 2'd3;
      end
      if (d[43] && !d[41]) return 2'd2;
      return (dpl >= eff) ? 2'd0 : 2'd3;
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: valid/allow/fault got %b expected %b", req, act, exp);
      end
   endtask

   task automatic run(input string req, input logic rd, input logic [1:0] cl,
         input logic [15:0] sel, input logic [63:0] d);
      logic [1:0] ef;
      ef = model(rd, cl, sel, d);
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; cur_lvl = cl; selector = sel; descriptor = d;
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {out_valid, out_allow, out_fault}, {1'b1, ef == 2'd0, ef});
   endtask

   task automatic t_reset;
      check("R1", {out_valid, out_allow, out_fault}, 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      check("R1", {out_valid, out_allow, out_fault}, 4'b0000);
   endtask

   task automatic t_absent;
      for (int k = 0; k < 8; k++)
         run("R3", k[0], k[2:1], 16'h0003, mk_desc(1'b0, 2'd3, k[1], k[2], k[0], 1'b1, 1'b0, 32'h1234_5678));
   endtask

   task automatic t_system;
      run("R4", 1'b0, 2'd0, 16'h0008, mk_desc(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0));
      run("R4", 1'b1, 2'd0, 16'h0008, mk_desc(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0));
   endtask

   task automatic t_jump_data;
      run("R5", 1'b0, 2'd0, 16'h0010, mk_desc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF));
      run("R5", 1'b0, 2'd3, 16'h0013, mk_desc(1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0));
   endtask

   task automatic t_jump_exact;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            for (int p = 0; p < 4; p++)
               run("R6", 1'b0, 2'(c), 16'(r) | 16'h0020,
                   mk_desc(1'b1, 2'(p), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0));
   endtask

   task automatic t_jump_conf;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            for (int p = 0; p < 4; p++)
               run("R7", 1'b0, 2'(c), 16'(r) | 16'h0028,
                   mk_desc(1'b1, 2'(p), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0));
   endtask

   task automatic t_read_data;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            for (int p = 0; p < 4; p++)
               run("R8", 1'b1, 2'(c), 16'(r) | 16'h0030,
                   mk_desc(1'b1, 2'(p), 1'b1, 1'b0, 1'((c + p) & 1), 1'b0, 1'b0, 32'h0));
   endtask

   task automatic t_read_code;
      run("R9", 1'b1, 2'd0, 16'h0038, mk_desc(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0));
      run("R9", 1'b1, 2'd0, 16'h0038, mk_desc(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0));
      run("R9", 1'b1, 2'd2, 16'h0039, mk_desc(1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0));
   endtask

   task automatic t_ignored;
      for (int k = 0; k < 6; k++) begin
         run("R10", 1'b0, 2'd2, 16'hA5A4 ^ (16'(k) << 3), mk_desc(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, k[0], 32'h9E37_79B9 * k));
         run("R10", 1'b1, 2'd1, 16'h5A5D ^ (16'(k) << 2) & 16'hFFFC, mk_desc(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, k[1], 32'hC2B2_AE35 * k));
      end
   endtask

   task automatic t_hold;
      logic [3:0] snap;
      run("R11", 1'b1, 2'd3, 16'h0003, mk_desc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0));
      snap = {1'b0, out_allow, out_fault};
      @(negedge clk);
      descriptor = 64'd0; req_read = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2", {out_valid, out_allow, out_fault}, snap);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      t_absent;
      t_system;
      t_jump_data;
      t_jump_exact;
      t_jump_conf;
      t_read_data;
      t_read_code;
      t_ignored;
      t_hold;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule